// File: doc/BRIEF.md
# Incremental Encoder Front-End

This block sits in front of one position-counter channel. It takes the raw A, B and index lines of an incremental encoder, brings them into the clock domain, and turns their transitions into a one-cycle count strobe with a direction bit for the counter. A two-bit mode input selects the decoding:

- step/direction, where A is the step and B is the direction;
- quadrature at single resolution;
- quadrature at double resolution;
- quadrature at quadruple resolution.

The index line is also decoded. Its active level is selectable. In quadrature modes the index can be gated by the A/B state. A qualified index edge raises an index strobe, and when enabled a preset-load request for the counter. The counter itself and any bus access are outside this block; all configuration inputs are static levels driven by the surrounding channel logic.

Top module: `enc_front`

## Requirements
- R1: While reset is asserted, `cnt_en`, `idx_evt` and `preset_ld` are 0 and `cnt_up` is 1 (up).
- R2: With `mode` = 00 (step/direction), each rising edge of synchronized A gives one count strobe. `cnt_up` follows synchronized B (1 = up), and B edges give no count.
- R3: With `mode` = 01 (single resolution), a count is produced on a rising A edge that moves forward, or on a falling A edge that moves backward. Other A edges and all B edges give no count.
- R4: With `mode` = 10 (double resolution), every A edge counts and B edges never count.
- R5: With `mode` = 11 (quadruple resolution), every single edge of A or B counts. In all quadrature modes the direction comes from the phase relationship:
  - the Gray sequence AB = 00, 10, 11, 01 (A leading B) is up;
  - the reverse sequence is down.
- R6: In quadrature modes, a sample in which A and B both change gives no count and leaves `cnt_up` unchanged.
- R7: When `ab_en` is 0, no count strobe is produced. Direction tracking still updates.
- R8: The index is active when its level equals `idx_pos` (1 = active high, 0 = active low). When the index becomes active, `idx_evt` pulses for exactly one cycle.
- R9: With `sync_req` = 1 in a quadrature mode, the index is qualified by A = 1 and B = 1. `idx_evt` fires only when the index is active while A and B are both high.
- R10: In step/direction mode the synchronous request is overridden: `sync_eff` reads 0 and the index is decoded ungated.
- R11: `preset_ld` pulses together with `idx_evt` when `preset_on_idx` is 1, and stays 0 when it is 0.
- R12: A change on A, B or index is reflected on the strobes three rising clock edges later (two synchronizer stages plus one output register). Each transition yields at most one strobe, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | 1 | Encoder A / step input, asynchronous |
| b_in | input | 1 | Encoder B / direction input, asynchronous |
| idx_in | input | 1 | Encoder index input, asynchronous |
| mode | input | 2 | Decoding select: 00 step/dir, 01 x1, 10 x2, 11 x4 |
| idx_pos | input | 1 | Index active level: 1 high, 0 low |
| sync_req | input | 1 | Request A/B-qualified index |
| ab_en | input | 1 | Enable count strobes |
| preset_on_idx | input | 1 | Let index events request a preset load |
| cnt_en | output | 1 | One-cycle count strobe |
| cnt_up | output | 1 | Count direction, 1 up, 0 down |
| idx_evt | output | 1 | One-cycle qualified index strobe |
| preset_ld | output | 1 | One-cycle preset-load request |
| sync_eff | output | 1 | Effective synchronous-index setting |

## Verification
Every strobe and the direction bit are due in the cycle that follows the third rising edge after an input change. Each change is held for four cycles, and the bench samples on falling edges. The expected values are compared in the third sampled cycle. The strobes are required to be low in the other three, which covers the one-cycle width and the absence of extra pulses. Configuration changes are followed by an unchecked settling interval, because they act on the decoder without passing through the synchronizer.

// File: rtl/enc_front.sv
module enc_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_in,
  input  logic       b_in,
  input  logic       idx_in,
  input  logic [1:0] mode,
  input  logic       idx_pos,
  input  logic       sync_req,
  input  logic       ab_en,
  input  logic       preset_on_idx,
  output logic       cnt_en,
  output logic       cnt_up,
  output logic       idx_evt,
  output logic       preset_ld,
  output logic       sync_eff
);

  localparam logic [1:0] M_STEP = 2'b00;
  localparam logic [1:0] M_X1   = 2'b01;
  localparam logic [1:0] M_X2   = 2'b10;
  localparam logic [1:0] M_X4   = 2'b11;

  logic [SYNC_STAGES-1:0][2:0] sh;
  logic a_s, b_s, i_s;
  logic a_d, b_d, qual_d;
  logic da, db, valid, step_up;
  logic hit, dir_nx, act, qual, ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-2:0], {a_in, b_in, idx_in}};
  end

  assign {a_s, b_s, i_s} = sh[SYNC_STAGES-1];

  assign da      = a_s ^ a_d;
  assign db      = b_s ^ b_d;
  assign valid   = da ^ db;
  assign step_up = da ? (a_s ^ b_s) : ~(a_s ^ b_s);

  always_comb begin
    hit    = 1'b0;
    dir_nx = cnt_up;
    case (mode)
      M_STEP: begin
        hit    = a_s & ~a_d;
        dir_nx = b_s;
      end
      M_X1: hit = valid & da & (a_s == step_up);
      M_X2: hit = valid & da;
      M_X4: hit = valid;
      default: hit = 1'b0;
    endcase
    if (mode != M_STEP && valid) dir_nx = step_up;
  end

  assign sync_eff = sync_req & (mode != M_STEP);
  assign act      = idx_pos ? i_s : ~i_s;
  assign qual     = act & (~sync_eff | (a_s & b_s));
  assign ev       = qual & ~qual_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_d       <= 1'b0;
      b_d       <= 1'b0;
      qual_d    <= 1'b1;
      cnt_up    <= 1'b1;
      cnt_en    <= 1'b0;
      idx_evt   <= 1'b0;
      preset_ld <= 1'b0;
    end else begin
      a_d       <= a_s;
      b_d       <= b_s;
      qual_d    <= qual;
      cnt_up    <= dir_nx;
      cnt_en    <= hit & ab_en;
      idx_evt   <= ev;
      preset_ld <= ev & preset_on_idx;
    end
  end

  // R7
  ab_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_en |=> !cnt_en);

  // R12
  no_change_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_s == a_d && b_s == b_d) |=> !cnt_en);

  // R4
  x2_b_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_X2 && a_s == a_d) |=> !cnt_en);

  // R8
  idx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_evt |=> !idx_evt);

  // R11
  preset_with_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preset_ld |-> idx_evt);

endmodule

// File: tb/enc_front_bench.sv
module enc_front_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_in = 0, b_in = 0, idx_in = 0;
  logic [1:0] mode = 2'b00;
  logic idx_pos = 1, sync_req = 0, ab_en = 1, preset_on_idx = 0;
  logic cnt_en, cnt_up, idx_evt, preset_ld, sync_eff;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit dir_exp = 1;

  always #10 clk = ~clk;

  enc_front u_enc_front (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .idx_in(idx_in),
    .mode(mode), .idx_pos(idx_pos), .sync_req(sync_req), .ab_en(ab_en),
    .preset_on_idx(preset_on_idx), .cnt_en(cnt_en), .cnt_up(cnt_up),
    .idx_evt(idx_evt), .preset_ld(preset_ld), .sync_eff(sync_eff));

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic int gpos(bit a, bit b);
    return a ? (b ? 2 : 1) : (b ? 3 : 0);
  endfunction

  function automatic bit qual_of(bit a, bit b, bit i);
    bit act = idx_pos ? i : ~i;
    bit se = sync_req && mode != 2'b00;
    return act && (!se || (a && b));
  endfunction

  task automatic settle();
    repeat (6) @(negedge clk);
    if (mode == 2'b00) dir_exp = b_in;
  endtask

  task automatic cfg(input logic [1:0] m, input bit pol, input bit sr,
                     input bit en, input bit pon);
    @(negedge clk);
    mode = m; idx_pos = pol; sync_req = sr; ab_en = en; preset_on_idx = pon;
    settle();
  endtask

  task automatic step(input bit a, input bit b, input bit i);
    bit pa = a_in, pb = b_in, pi = idx_in;
    bit da = a != pa, db = b != pb;
    bit c = 0, up;
    bit ev, pl;
    string ct;
    ct = (mode == 2'b00) ? "R2" : (mode == 2'b01) ? "R3" : (mode == 2'b10) ? "R4" : "R5";
    if (mode == 2'b00) begin
      c = !pa && a;
      dir_exp = b;
    end else if (da ^ db) begin
      up = ((gpos(a, b) - gpos(pa, pb)) & 3) == 1;
      dir_exp = up;
      case (mode)
        2'b01: c = da && ((a && up) || (!a && !up));
        2'b10: c = da;
        default: c = 1;
      endcase
    end else if (da && db) ct = "R6";
    if (!ab_en) begin c = 0; ct = "R7"; end
    ev = qual_of(a, b, i) && !qual_of(pa, pb, pi);
    pl = ev && preset_on_idx;
    a_in = a; b_in = b; idx_in = i;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k == 3) begin
        check({ct, " count strobe"}, cnt_en, c);
        check({ct, " direction"}, cnt_up, dir_exp);
        check((sync_req && mode != 2'b00) ? "R9 index event" :
              (sync_req ? "R10 index event" : "R8 index event"), idx_evt, ev);
        check("R11 preset load", preset_ld, pl);
      end else begin
        check("R12 strobes idle outside due cycle", cnt_en | idx_evt | preset_ld, 1'b0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 cnt_en in reset", cnt_en, 1'b0);
    check("R1 cnt_up in reset", cnt_up, 1'b1);
    check("R1 idx_evt in reset", idx_evt, 1'b0);
    check("R1 preset_ld in reset", preset_ld, 1'b0);
    rst_n = 1'b1;
    settle();

    // R2 step/direction
    cfg(2'b00, 1, 0, 1, 0);
    step(1, 0, 0); step(0, 0, 0); step(0, 1, 0); step(1, 1, 0); step(0, 1, 0);
    // R3 single resolution forward then backward
    cfg(2'b01, 1, 0, 1, 0);
    step(0, 0, 0);
    step(1, 0, 0); step(1, 1, 0); step(0, 1, 0); step(0, 0, 0);
    step(0, 1, 0); step(1, 1, 0); step(1, 0, 0); step(0, 0, 0);
    // R4 double resolution
    cfg(2'b10, 1, 0, 1, 0);
    step(1, 0, 0); step(1, 1, 0); step(0, 1, 0); step(0, 0, 0);
    // R5 quadruple resolution, both directions
    cfg(2'b11, 1, 0, 1, 0);
    step(1, 0, 0); step(1, 1, 0); step(0, 1, 0); step(1, 1, 0); step(1, 0, 0);
    // R6 illegal double change
    step(0, 1, 0); step(1, 0, 0);
    // R7 disabled strobes, direction still tracked
    cfg(2'b11, 1, 0, 0, 0);
    step(1, 1, 0); step(0, 1, 0); step(0, 0, 0);
    // R8 active-low index, R11 preset
    cfg(2'b11, 0, 0, 1, 1);
    step(0, 0, 1); step(0, 0, 0); step(0, 0, 1);
    // R9 gated index
    cfg(2'b10, 1, 1, 1, 1);
    check("R9 sync_eff in quadrature", sync_eff, 1'b1);
    step(0, 0, 1); step(1, 0, 1); step(1, 1, 1); step(1, 1, 0); step(1, 1, 1);
    // R10 sync request ignored in step/direction
    cfg(2'b00, 1, 1, 1, 0);
    check("R10 sync_eff forced low", sync_eff, 1'b0);
    step(1, 1, 0); step(0, 0, 1); step(0, 0, 0);

    for (int blk = 0; blk < 12; blk++) begin
      cfg(2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
          ($urandom_range(0, 4) != 0), 1'($urandom));
      for (int s = 0; s < 40; s++)
        step(1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule